// File: doc/BRIEF.md
# Serial channel interrupt prioritiser

This block sits beside one channel of a 16550-family UART and turns the channel's event strobes into a single active-high interrupt request plus a 3-bit level code that names the most urgent pending cause. The host programs an 8-bit enable byte through a one-cycle write strobe. Event strobes come from the receiver, the transmitter, the modem-line logic, the character matcher and the flow-control line watchers. Each strobe sets a sticky pending flag. The flag stays set until the matching acknowledge strobe clears it.

Several enable bits change meaning with the framing and compatibility mode inputs. With nine-bit framing, bit 5 masks matches against the programmed special characters. In the extended register mode without nine-bit framing, bit 5 turns on XOFF and XOFF2 detection. In plain compatibility mode, bit 5 is a second sleep control. The RTS/CTS masks in bits 6 and 7 only take effect in the extended mode. The request output ignores the modem-control output-enable bit; that bit is not an input of this block. The block also drives a registered sleep request that gates the channel clock.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the enable byte is 0x00, `irq` is 0, `irq_id` is 0 and `sleep_req` is 0.
- R2: Enable bit 0 masks receive-data (`irq_id` 2). Bit 1 masks transmitter-empty (`irq_id` 3). Bit 3 masks modem-status (`irq_id` 4). A pending cause whose bit is 0 raises nothing.
- R3: Enable bit 2 masks line-status (`irq_id` 1). When `nine_bit` is 1, the same bit also masks the address-character cause, which reports `irq_id` 1. When `nine_bit` is 0, `ev_addr` is not recorded.
- R4: Only the most urgent enabled pending cause is reported. The levels run 1 (most urgent) to 6, and `irq_id` 0 means none. `irq` is 1 exactly when `irq_id` is nonzero.
- R5: With `nine_bit`=1, `ev_spchar` records a special-character cause. It reports `irq_id` 5 only while enable bit 5 is 1.
- R6: With `nine_bit`=0 and `enhanced`=1, an XOFF or XOFF2 strobe records a special-character cause (`irq_id` 5) only when enable bit 5 is 1 at that time. An XOFF strobe also needs `flow_ctl` nonzero. An XOFF2 strobe also needs `xoff2_en`=1.
- R7: With `nine_bit`=0 and `enhanced`=0, no special-character cause is ever recorded.
- R8: `sleep_req` is enable bit 4 ORed with enable bit 5. Bit 5 only counts when `nine_bit`=0 and `enhanced`=0.
- R9: RTS and CTS change causes report `irq_id` 6. In enhanced mode they are masked by enable bits 6 and 7 respectively. Otherwise they are always enabled.
- R10: Each acknowledge clears its pending causes. `ack_line` clears both level-1 causes and `ack_flow` clears RTS and CTS. An event in the same cycle as its acknowledge wins. A strobe sampled at one clock edge shows on the outputs after the next edge.
- R11: A write to the enable byte sampled at one edge affects `irq`, `irq_id` and `sleep_req` one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_we | input | 1 | Enable byte write strobe |
| ier_wdata | input | 8 | Enable byte write data |
| nine_bit | input | 1 | Nine-bit framing active |
| enhanced | input | 1 | Extended register mode active |
| flow_ctl | input | 4 | In-band flow-control selection, nonzero = selected |
| xoff2_en | input | 1 | XOFF2 detection allowed |
| ev_line | input | 1 | Receiver line-status event |
| ev_addr | input | 1 | Character with ninth bit set received |
| ev_rxdata | input | 1 | Receive data available |
| ev_txempty | input | 1 | Transmitter empty |
| ev_modem | input | 1 | Modem status change |
| ev_spchar | input | 1 | Special-character match (nine-bit framing) |
| ev_xoff | input | 1 | XOFF character seen |
| ev_xoff2 | input | 1 | XOFF2 character seen |
| ev_rts | input | 1 | RTS change |
| ev_cts | input | 1 | CTS change |
| ack_line | input | 1 | Line status read |
| ack_rxdata | input | 1 | Receive data read |
| ack_txempty | input | 1 | Transmit write or ID read |
| ack_modem | input | 1 | Modem status read |
| ack_spchar | input | 1 | Special-character cause read |
| ack_flow | input | 1 | RTS/CTS cause read |
| irq | output | 1 | Registered interrupt request |
| irq_id | output | 3 | Level of the reported cause, 0 = none |
| sleep_req | output | 1 | Registered channel clock-off request |

## Verification
The bench aims at the bit-5 corners in each of the three mode combinations. If the XOFF gate were missing, the design would report level 5 with detection disabled. If the alternate sleep leaked into other modes, `sleep_req` would rise under nine-bit framing. It drives RTS/CTS outside enhanced mode with a zero enable byte; a design that honoured the mask there would stay silent. It also drives an acknowledge together with a fresh event, where a design that let the acknowledge win would lose an interrupt. It checks that an address character is dropped when nine-bit framing is off, and a design that recorded it would report level 1 later. It checks the one-edge delay after an enable write, where an extra or a missing register would shift `irq` by a cycle.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_SRC = 8;
  localparam int LVL_W = 3;
  localparam int DATA_W = 8;

  // source slots, ordered from most to least urgent
  localparam int S_LINE = 0;
  localparam int S_ADDR = 1;
  localparam int S_RXD  = 2;
  localparam int S_TXE  = 3;
  localparam int S_MDM  = 4;
  localparam int S_SPC  = 5;
  localparam int S_RTS  = 6;
  localparam int S_CTS  = 7;

  function automatic logic [LVL_W-1:0] src_level(input int idx);
    case (idx)
      S_LINE, S_ADDR: src_level = 3'd1;
      S_RXD:          src_level = 3'd2;
      S_TXE:          src_level = 3'd3;
      S_MDM:          src_level = 3'd4;
      S_SPC:          src_level = 3'd5;
      default:        src_level = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
  import uart_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              nine_bit,
  input  logic              enhanced,
  output logic [N_SRC-1:0]  src_mask,
  output logic              spc_detect_en,
  output logic              sleep_req
);
  logic [DATA_W-1:0] en_q;
  logic              alt_sleep;

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (we) en_q <= wdata;
  end

  assign alt_sleep     = en_q[5] && !nine_bit && !enhanced;
  assign spc_detect_en = en_q[5] && enhanced && !nine_bit;

  always_comb begin
    src_mask          = '0;
    src_mask[S_LINE]  = en_q[2];
    src_mask[S_ADDR]  = en_q[2] && nine_bit;
    src_mask[S_RXD]   = en_q[0];
    src_mask[S_TXE]   = en_q[1];
    src_mask[S_MDM]   = en_q[3];
    src_mask[S_SPC]   = nine_bit ? en_q[5] : enhanced;
    src_mask[S_RTS]   = enhanced ? en_q[6] : 1'b1;
    src_mask[S_CTS]   = enhanced ? en_q[7] : 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) sleep_req <= 1'b0;
    else     sleep_req <= en_q[4] || alt_sleep;
  end

  // R8
  sleep_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (we && wdata[4]) |=> ##1 sleep_req);
  // R8
  nine_no_alt_chk: assert property (@(posedge clk) disable iff (rst)
    (nine_bit && !en_q[4]) |=> !sleep_req);
endmodule

// File: rtl/uart_irq_pending.sv
module uart_irq_pending
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] set_v,
  input  logic [N_SRC-1:0] clr_v,
  output logic [N_SRC-1:0] pend
);
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)           pend[g] <= 1'b0;
      else if (set_v[g]) pend[g] <= 1'b1;
      else if (clr_v[g]) pend[g] <= 1'b0;
    end

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
      set_v[g] |=> pend[g]);
    // R10
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (clr_v[g] && !set_v[g]) |=> !pend[g]);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] mask,
  output logic             irq_q,
  output logic [LVL_W-1:0] id_q
);
  logic [N_SRC-1:0] live;
  logic [LVL_W-1:0] lvl_n;

  assign live = pend & mask;

  always_comb begin
    lvl_n = '0;
    for (int i = N_SRC - 1; i >= 0; i--)
      if (live[i]) lvl_n = src_level(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= |live;
      id_q  <= lvl_n;
    end
  end

  // R4
  irq_id_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (id_q != '0));
  // R4
  id_range_chk: assert property (@(posedge clk) disable iff (rst)
    id_q != 3'd7);
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        ier_we,
  input  logic [7:0]  ier_wdata,
  input  logic        nine_bit,
  input  logic        enhanced,
  input  logic [3:0]  flow_ctl,
  input  logic        xoff2_en,
  input  logic        ev_line,
  input  logic        ev_addr,
  input  logic        ev_rxdata,
  input  logic        ev_txempty,
  input  logic        ev_modem,
  input  logic        ev_spchar,
  input  logic        ev_xoff,
  input  logic        ev_xoff2,
  input  logic        ev_rts,
  input  logic        ev_cts,
  input  logic        ack_line,
  input  logic        ack_rxdata,
  input  logic        ack_txempty,
  input  logic        ack_modem,
  input  logic        ack_spchar,
  input  logic        ack_flow,
  output logic        irq,
  output logic [2:0]  irq_id,
  output logic        sleep_req
);
  logic [N_SRC-1:0] mask, set_v, clr_v, pend;
  logic             spc_det_en, flow_hit;

  uart_irq_enable u_en (
    .clk(clk), .rst(rst), .we(ier_we), .wdata(ier_wdata),
    .nine_bit(nine_bit), .enhanced(enhanced),
    .src_mask(mask), .spc_detect_en(spc_det_en), .sleep_req(sleep_req)
  );

  // XOFF / XOFF2 only count when detection is switched on
  assign flow_hit = spc_det_en &&
                    (((flow_ctl != '0) && ev_xoff) || (xoff2_en && ev_xoff2));

  always_comb begin
    set_v         = '0;
    set_v[S_LINE] = ev_line;
    set_v[S_ADDR] = ev_addr && nine_bit;
    set_v[S_RXD]  = ev_rxdata;
    set_v[S_TXE]  = ev_txempty;
    set_v[S_MDM]  = ev_modem;
    set_v[S_SPC]  = nine_bit ? ev_spchar : flow_hit;
    set_v[S_RTS]  = ev_rts;
    set_v[S_CTS]  = ev_cts;

    clr_v         = '0;
    clr_v[S_LINE] = ack_line;
    clr_v[S_ADDR] = ack_line;
    clr_v[S_RXD]  = ack_rxdata;
    clr_v[S_TXE]  = ack_txempty;
    clr_v[S_MDM]  = ack_modem;
    clr_v[S_SPC]  = ack_spchar;
    clr_v[S_RTS]  = ack_flow;
    clr_v[S_CTS]  = ack_flow;
  end

  uart_irq_pending u_pend (
    .clk(clk), .rst(rst), .set_v(set_v), .clr_v(clr_v), .pend(pend)
  );

  uart_irq_prio u_prio (
    .clk(clk), .rst(rst), .pend(pend), .mask(mask),
    .irq_q(irq), .id_q(irq_id)
  );

  // R7
  compat_no_spc_chk: assert property (@(posedge clk) disable iff (rst)
    (!nine_bit && !enhanced) |-> !set_v[S_SPC]);
  // R3
  addr_dropped_chk: assert property (@(posedge clk) disable iff (rst)
    (!nine_bit && !pend[S_ADDR]) |=> !pend[S_ADDR]);
endmodule

// File: tb/uart_irq_ctrl_bench.sv
module uart_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ier_we = 1'b0;
  logic [7:0] ier_wdata = '0;
  logic       nine_bit = 1'b0, enhanced = 1'b0, xoff2_en = 1'b0;
  logic [3:0] flow_ctl = '0;
  logic [9:0] ev_v = '0;   // 0 line,1 addr,2 rx,3 tx,4 modem,5 spchar,6 xoff,7 xoff2,8 rts,9 cts
  logic [5:0] ack_v = '0;  // 0 line,1 rx,2 tx,3 modem,4 spchar,5 flow
  logic       irq, sleep_req;
  logic [2:0] irq_id;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit mon_on = 0;

  always #2 clk = ~clk;

  uart_irq_ctrl u_uart_irq_ctrl (
    .clk(clk), .rst(rst), .ier_we(ier_we), .ier_wdata(ier_wdata),
    .nine_bit(nine_bit), .enhanced(enhanced), .flow_ctl(flow_ctl), .xoff2_en(xoff2_en),
    .ev_line(ev_v[0]), .ev_addr(ev_v[1]), .ev_rxdata(ev_v[2]), .ev_txempty(ev_v[3]),
    .ev_modem(ev_v[4]), .ev_spchar(ev_v[5]), .ev_xoff(ev_v[6]), .ev_xoff2(ev_v[7]),
    .ev_rts(ev_v[8]), .ev_cts(ev_v[9]),
    .ack_line(ack_v[0]), .ack_rxdata(ack_v[1]), .ack_txempty(ack_v[2]),
    .ack_modem(ack_v[3]), .ack_spchar(ack_v[4]), .ack_flow(ack_v[5]),
    .irq(irq), .irq_id(irq_id), .sleep_req(sleep_req)
  );

  // ---- reference model built from the requirements ----
  logic [7:0] m_ier = '0, m_pend = '0;
  logic       e_irq = 0, e_slp = 0;
  logic [2:0] e_id = 0;

  function automatic logic [7:0] m_mask(logic [7:0] ie, logic nb, logic en);
    return {en ? ie[7] : 1'b1, en ? ie[6] : 1'b1, nb ? ie[5] : en,
            ie[3], ie[1], ie[0], ie[2] & nb, ie[2]};
  endfunction

  function automatic logic [2:0] m_level(logic [7:0] live);
    logic [2:0] r = 0;
    if (live[7] | live[6]) r = 6;
    if (live[5]) r = 5;
    if (live[4]) r = 4;
    if (live[3]) r = 3;
    if (live[2]) r = 2;
    if (live[1] | live[0]) r = 1;
    return r;
  endfunction

  always @(posedge clk) begin
    logic [7:0] s, a, live;
    s = {ev_v[9], ev_v[8],
         nine_bit ? ev_v[5] : (enhanced & m_ier[5] &
           (((flow_ctl != 0) & ev_v[6]) | (xoff2_en & ev_v[7]))),
         ev_v[4], ev_v[3], ev_v[2], ev_v[1] & nine_bit, ev_v[0]};
    a = {ack_v[5], ack_v[5], ack_v[4], ack_v[3], ack_v[2], ack_v[1], ack_v[0], ack_v[0]};
    live = m_pend & m_mask(m_ier, nine_bit, enhanced);
    if (rst) begin
      m_ier <= 0; m_pend <= 0; e_irq <= 0; e_id <= 0; e_slp <= 0;
    end else begin
      e_irq  <= |live;
      e_id   <= m_level(live);
      e_slp  <= m_ier[4] | (m_ier[5] & !nine_bit & !enhanced);
      m_pend <= (m_pend & ~a) | s;
      if (ier_we) m_ier <= ier_wdata;
    end
  end

  task automatic chk(string tag, logic [2:0] got, logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d t=%0t", tag, got, exp, $time);
    end
  endtask

  // running comparison against the model (R4 R10 R11)
  always @(negedge clk) if (mon_on && !rst) begin
    chk("R4 R10 model irq", {2'b0, irq}, {2'b0, e_irq});
    chk("R4 R10 model id", irq_id, e_id);
    chk("R8 R11 model sleep", {2'b0, sleep_req}, {2'b0, e_slp});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic wr(logic [7:0] v);
    ier_we = 1; ier_wdata = v; tick; ier_we = 0; tick;
  endtask
  task automatic pulse(logic [9:0] e, logic [5:0] k);
    ev_v = e; ack_v = k; tick; ev_v = 0; ack_v = 0; tick;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) tick;
    rst = 0; tick;
    // R1 reset state
    chk("R1 irq", {2'b0, irq}, 0);
    chk("R1 id", irq_id, 0);
    chk("R1 sleep", {2'b0, sleep_req}, 0);
    mon_on = 1;

    // R2 masked then enabled
    pulse(10'b0000000100, 0);
    chk("R2 masked rx", irq_id, 0);
    // R11 write timing: one edge, not yet; second edge, visible
    ier_we = 1; ier_wdata = 8'h01; tick; ier_we = 0;
    chk("R11 before", {2'b0, irq}, 0);
    tick;
    chk("R11 after", irq_id, 2);
    wr(8'h0F);
    pulse(10'b0000001000, 0);  chk("R4 rx over tx", irq_id, 2);
    pulse(10'b0000000001, 0);  chk("R3 line", irq_id, 1);
    pulse(0, 6'b000001);       chk("R10 ack line", irq_id, 2);
    pulse(0, 6'b000010);       chk("R2 tx", irq_id, 3);
    pulse(0, 6'b000100);       chk("R10 all clear", irq_id, 0);
    pulse(10'b0000010000, 0);  chk("R2 modem", irq_id, 4);
    pulse(0, 6'b001000);

    // R3 address char
    pulse(10'b0000000010, 0);  chk("R3 addr ignored", irq_id, 0);
    nine_bit = 1; tick;        chk("R3 addr still none", irq_id, 0);
    pulse(10'b0000000010, 0);  chk("R3 addr nine", irq_id, 1);
    pulse(0, 6'b000001);

    // R5 nine-bit special char
    wr(8'h00);
    pulse(10'b0000100000, 0);  chk("R5 masked", irq_id, 0);
    wr(8'h20);                 chk("R5 enabled", irq_id, 5);
    chk("R8 no alt sleep nine", {2'b0, sleep_req}, 0);
    pulse(0, 6'b010000);

    // R6 enhanced XOFF / XOFF2
    nine_bit = 0; enhanced = 1; flow_ctl = 0; xoff2_en = 0;
    pulse(10'b0001000000, 0);  chk("R6 xoff no flow", irq_id, 0);
    flow_ctl = 4'h8;
    pulse(10'b0001000000, 0);  chk("R6 xoff flow", irq_id, 5);
    pulse(0, 6'b010000);
    pulse(10'b0010000000, 0);  chk("R6 xoff2 off", irq_id, 0);
    xoff2_en = 1;
    pulse(10'b0010000000, 0);  chk("R6 xoff2 on", irq_id, 5);
    pulse(0, 6'b010000);
    wr(8'h00);
    pulse(10'b0011000000, 0);
    wr(8'h20);                 chk("R6 detect was off", irq_id, 0);

    // R7 R8 compatibility mode
    enhanced = 0; tick; tick;
    chk("R8 alt sleep", {2'b0, sleep_req}, 1);
    pulse(10'b0011100000, 0);  chk("R7 no spchar", irq_id, 0);
    wr(8'h10);                 chk("R8 main sleep", {2'b0, sleep_req}, 1);
    wr(8'h00);                 chk("R8 sleep off", {2'b0, sleep_req}, 0);

    // R9 RTS/CTS
    pulse(10'b0100000000, 0);  chk("R9 rts forced on", irq_id, 6);
    pulse(0, 6'b100000);       chk("R9 ack", irq_id, 0);
    enhanced = 1;
    pulse(10'b1000000000, 0);  chk("R9 cts masked", irq_id, 0);
    wr(8'h80);                 chk("R9 cts enabled", irq_id, 6);
    pulse(0, 6'b100000);

    // R10 event beats ack
    wr(8'h08);
    pulse(10'b0000010000, 6'b001000); chk("R10 event wins", irq_id, 4);
    pulse(0, 6'b001000);

    // random phase, checked by the model monitor
    for (int n = 0; n < 4000; n++) begin
      ev_v = '0; ack_v = '0; ier_we = 0;
      for (int b = 0; b < 10; b++) ev_v[b] = ($urandom % 8) == 0;
      for (int b = 0; b < 6; b++) ack_v[b] = ($urandom % 5) == 0;
      if (($urandom % 12) == 0) begin ier_we = 1; ier_wdata = 8'($urandom); end
      if (($urandom % 40) == 0) begin
        nine_bit = 1'($urandom); enhanced = 1'($urandom);
        flow_ctl = 4'($urandom % 3); xoff2_en = 1'($urandom);
      end
      tick;
    end
    ev_v = 0; ack_v = 0; ier_we = 0;
    tick; tick;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule